// File: doc/BRIEF.md
# Port Shutdown String Detector

This block snoops byte writes on a simple I/O write interface and raises a power-off request when software writes a fixed eight-character ASCII word to one trigger address, one byte at a time. Firmware that wants the system turned off writes the letters of the word, in order, to that port. The block keeps a small index of how many letters have matched so far. When the last letter arrives, it emits a single-cycle request that the power sequencer acts on.

The matcher is deliberately simple. A wrong byte sends the index back to zero, and that byte is not tried again as the first letter. A write that hits any other address leaves the index alone, so unrelated I/O may fall between the letters. The address, the word and its length are parameters. The defaults are address 0x8900 and the word "Shutdown".

Top module: `shutdown_seq_detect`

## Requirements
- R1: Only cycles with `ioWrEn` high and `ioAddr` equal to the trigger address (default 0x8900) can advance or clear the match index. Cycles with `ioWrEn` low, or writes to any other address, never cause a request.
- R2: The word is compared byte for byte and case-sensitively. With the default, the first byte written must be 0x53 ('S') and the last 0x6E ('n'). Writing "shutdown" (first byte 0x73) gives no request.
- R3: A trigger-address write whose byte equals the letter at the current index, and which is not the last letter, moves the index up by one.
- R4: A trigger-address write whose byte differs from the expected letter returns the index to zero. That byte is not compared again against the first letter, so "SShutdown" gives no request.
- R5: A write that matches the eighth letter makes `shutReq` high for exactly one cycle. The pulse is visible in the clock cycle after the edge that samples the write, and no terminating byte is needed.
- R6: After a completed match the index is zero, so the whole word written again gives a second request.
- R7: Synchronous reset clears the index and holds `shutReq` low. A word split by a reset gives no request.
- R8: Writes to other addresses, and idle cycles, do not change the index. A word interleaved with such traffic still gives a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ioAddr | input | ADDR_W (16) | I/O write address |
| ioWrEn | input | 1 | Write strobe, one cycle per byte |
| ioData | input | 8 | Written byte |
| shutReq | output | 1 | One-cycle power-off request |

## Verification
The index cannot be seen at the ports, so the hardest case to reach is a mismatch at an arbitrary depth. Observing the request alone does not show whether the index really returned to zero there. The bench sweeps every letter position against all 256 byte values. For each pair it writes the word with that byte substituted and then writes the clean word, so both the absence or presence of the first request and the return to zero before the second are judged from the request output. Directed runs add the repeated first letter, the wrong case, a reset partway through the word, and interleaved foreign and idle cycles.

// File: rtl/shutdown_seq_pkg.sv
package shutdown_seq_pkg;

  // Commands from control to the index datapath.
  typedef struct packed {
    logic advance;  // step index by one
    logic clear;    // return index to zero
  } idxCmdT;

endpackage

// File: rtl/shutdown_seq_datapath.sv
module shutdown_seq_datapath
  import shutdown_seq_pkg::*;
#(
  parameter int SEQ_LEN = 8,
  parameter logic [8*SEQ_LEN-1:0] SEQ_CHARS = "Shutdown",
  localparam int IDX_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  idxCmdT           cmd,
  input  logic [7:0]       wrByte,
  output logic             charMatch,
  output logic             atLast,
  output logic [IDX_W-1:0] matchIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);
  localparam int TAB_N = 1 << IDX_W;

  // Letter table; the leftmost character of the string is index 0.
  logic [7:0] charTab [TAB_N];

  genvar g;
  generate
    for (g = 0; g < TAB_N; g++) begin : g_tab
      if (g < SEQ_LEN) begin : g_real
        assign charTab[g] = SEQ_CHARS[8*(SEQ_LEN-1-g) +: 8];
      end else begin : g_pad
        assign charTab[g] = 8'h00;
      end
    end
  endgenerate

  logic [IDX_W-1:0] idxQ;
  logic [7:0]       expChar;

  assign expChar   = charTab[idxQ];
  assign charMatch = (wrByte == expChar);
  assign atLast    = (idxQ == LAST_IDX);
  assign matchIdx  = idxQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      idxQ <= '0;
    end else if (cmd.clear) begin
      idxQ <= '0;
    end else if (cmd.advance) begin
      idxQ <= idxQ + 1'b1;
    end
  end

endmodule

// File: rtl/shutdown_seq_control.sv
module shutdown_seq_control
  import shutdown_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h8900
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              charMatch,
  input  logic              atLast,
  output idxCmdT            cmd,
  output logic              shutReq
);

  logic addrHit;
  logic fireNow;
  logic reqQ;

  assign addrHit = ioWrEn && (ioAddr == TRIG_ADDR);
  assign fireNow = addrHit && charMatch && atLast;

  always_comb begin
    cmd         = '0;
    cmd.advance = addrHit && charMatch && !atLast;
    // Mismatch or completion both return to the start; no retry of the byte.
    cmd.clear   = addrHit && (!charMatch || atLast);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqQ <= 1'b0;
    end else begin
      reqQ <= fireNow;
    end
  end

  assign shutReq = reqQ;

endmodule

// File: rtl/shutdown_seq_detect.sv
module shutdown_seq_detect
  import shutdown_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h8900,
  parameter int SEQ_LEN = 8,
  parameter logic [8*SEQ_LEN-1:0] SEQ_CHARS = "Shutdown",
  localparam int IDX_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic [7:0]        ioData,
  output logic              shutReq
);

  idxCmdT           idxCmd;
  logic             charMatch;
  logic             atLast;
  logic [IDX_W-1:0] matchIdx;

  shutdown_seq_control #(
    .ADDR_W   (ADDR_W),
    .TRIG_ADDR(TRIG_ADDR)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .ioAddr   (ioAddr),
    .ioWrEn   (ioWrEn),
    .charMatch(charMatch),
    .atLast   (atLast),
    .cmd      (idxCmd),
    .shutReq  (shutReq)
  );

  shutdown_seq_datapath #(
    .SEQ_LEN  (SEQ_LEN),
    .SEQ_CHARS(SEQ_CHARS)
  ) dp_i (
    .clk      (clk),
    .rst      (rst),
    .cmd      (idxCmd),
    .wrByte   (ioData),
    .charMatch(charMatch),
    .atLast   (atLast),
    .matchIdx (matchIdx)
  );

endmodule

// File: rtl/shutdown_seq_checker.sv
module shutdown_seq_checker #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 16'h8900,
  parameter int SEQ_LEN = 8,
  parameter logic [8*SEQ_LEN-1:0] SEQ_CHARS = "Shutdown",
  localparam int IDX_W = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWrEn,
  input logic [7:0]        ioData,
  input logic              shutReq,
  input logic [IDX_W-1:0]  matchIdx
);

  logic       hit;
  logic [7:0] wantChar;
  logic       lastPos;

  assign hit     = ioWrEn && (ioAddr == TRIG_ADDR);
  assign lastPos = (int'(matchIdx) == SEQ_LEN - 1);

  always_comb begin
    wantChar = 8'h00;
    for (int i = 0; i < SEQ_LEN; i++) begin
      if (int'(matchIdx) == i) wantChar = SEQ_CHARS[8*(SEQ_LEN-1-i) +: 8];
    end
  end

  AST_FOREIGN_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !shutReq); // R1

  AST_FOREIGN_HOLD_IDX: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(matchIdx)); // R8

  AST_STEP_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    (hit && ioData == wantChar && !lastPos) |=> (matchIdx == IDX_W'($past(matchIdx) + 1'b1))); // R3

  AST_MISMATCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (hit && ioData != wantChar) |=> (matchIdx == '0 && !shutReq)); // R4

  AST_COMPLETE_REQ: assert property (@(posedge clk) disable iff (rst)
    (hit && ioData == wantChar && lastPos) |=> shutReq); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    shutReq |=> !shutReq); // R5

  AST_IDX_ZERO_AFTER: assert property (@(posedge clk) disable iff (rst)
    shutReq |-> (matchIdx == '0)); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!shutReq && matchIdx == '0)); // R7

endmodule

bind shutdown_seq_detect shutdown_seq_checker #(
  .ADDR_W   (ADDR_W),
  .TRIG_ADDR(TRIG_ADDR),
  .SEQ_LEN  (SEQ_LEN),
  .SEQ_CHARS(SEQ_CHARS)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .ioAddr  (ioAddr),
  .ioWrEn  (ioWrEn),
  .ioData  (ioData),
  .shutReq (shutReq),
  .matchIdx(matchIdx)
);

// File: tb/shutdown_seq_detect_tb.sv
`timescale 1ns/1ps
module shutdown_seq_detect_tb_top;

  localparam logic [15:0] TRIG  = 16'h8900;
  localparam logic [15:0] OTHER = 16'h8901;
  localparam logic [63:0] WORD  = "Shutdown";

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ioAddr = '0;
  logic        ioWrEn = 1'b0;
  logic [7:0]  ioData = '0;
  logic        shutReq;

  int total = 0;
  int bad = 0;
  int pulseCnt = 0;
  int doubleCnt = 0;
  logic prevReq = 1'b0;
  logic finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  shutdown_seq_detect dut_i (
    .clk    (clk),
    .rst    (rst),
    .ioAddr (ioAddr),
    .ioWrEn (ioWrEn),
    .ioData (ioData),
    .shutReq(shutReq)
  );

  always @(negedge clk) begin
    if (shutReq) pulseCnt++;
    if (shutReq && prevReq) doubleCnt++;
    prevReq = shutReq;
  end

  function automatic logic [7:0] letter(input int i);
    return WORD[8*(7-i) +: 8];
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One bus cycle; seen is shutReq one cycle after the sampling edge.
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en,
                    output logic seen);
    @(negedge clk);
    ioAddr = a; ioData = d; ioWrEn = en;
    @(negedge clk);
    seen = shutReq;
    ioWrEn = 1'b0;
  endtask

  task automatic wrWord(input int upTo);
    logic s;
    for (int i = 0; i < upTo; i++) wr(TRIG, letter(i), 1'b1, s);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 190000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    logic s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(shutReq == 1'b0, "R7 reset state", shutReq, 0);

    // R5: timing and width of the pulse
    wrWord(7);
    wr(TRIG, letter(7), 1'b1, s);
    check(s == 1'b1, "R5 pulse after final letter", s, 1);
    @(negedge clk);
    check(shutReq == 1'b0, "R5 pulse is one cycle", shutReq, 0);

    // R6: repeat immediately
    base = pulseCnt;
    wrWord(8); settle();
    check(pulseCnt - base == 1, "R6 second word fires", pulseCnt - base, 1);

    // R2: wrong case
    base = pulseCnt;
    wr(TRIG, 8'h73, 1'b1, s);
    for (int i = 1; i < 8; i++) wr(TRIG, letter(i), 1'b1, s);
    settle();
    check(pulseCnt == base, "R2 lowercase word ignored", pulseCnt - base, 0);

    // R4: doubled first letter does not retry
    base = pulseCnt;
    wr(TRIG, 8'h53, 1'b1, s);
    wrWord(8); settle();
    check(pulseCnt == base, "R4 SShutdown no request", pulseCnt - base, 0);
    base = pulseCnt;
    wrWord(8); settle();
    check(pulseCnt - base == 1, "R4 index back at zero", pulseCnt - base, 1);

    // R7: reset mid-word
    base = pulseCnt;
    wrWord(4);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 4; i < 8; i++) wr(TRIG, letter(i), 1'b1, s);
    settle();
    check(pulseCnt == base, "R7 reset breaks word", pulseCnt - base, 0);

    // R1/R8: interleaved foreign writes and idle strobes
    base = pulseCnt;
    for (int i = 0; i < 8; i++) begin
      wr(TRIG, letter(i), 1'b1, s);
      wr(OTHER, 8'h58, 1'b1, s);
      wr(TRIG, 8'h58, 1'b0, s);
    end
    settle();
    check(pulseCnt - base == 1, "R8 interleaved word fires", pulseCnt - base, 1);

    // R1: full word to a foreign address, or with strobe low
    base = pulseCnt;
    for (int i = 0; i < 8; i++) wr(OTHER, letter(i), 1'b1, s);
    for (int i = 0; i < 8; i++) wr(TRIG, letter(i), 1'b0, s);
    settle();
    check(pulseCnt == base, "R1 foreign or idle word ignored", pulseCnt - base, 0);

    // R3/R4/R6 sweep: every position, every byte value
    for (int p = 0; p < 8; p++) begin
      for (int v = 0; v < 256; v++) begin
        int want;
        want = (v == int'(letter(p))) ? 1 : 0;
        base = pulseCnt;
        for (int i = 0; i < 8; i++)
          wr(TRIG, (i == p) ? 8'(v) : letter(i), 1'b1, s);
        settle();
        check(pulseCnt - base == want, "R3 substituted byte outcome", pulseCnt - base, want);
        base = pulseCnt;
        wrWord(8); settle();
        check(pulseCnt - base == 1, "R4 clean word after substitution", pulseCnt - base, 1);
      end
    end

    check(doubleCnt == 0, "R5 no back-to-back request", doubleCnt, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule